// File: doc/BRIEF.md
# Coherence Probe Queue With Barrier Drain

This block sits on the incoming coherence path of one processor's cache. Invalidation probes from the interconnect are pushed into a FIFO and acknowledged in the cycle they are taken. The acknowledgment does not wait for the line to be invalidated. Queued probes are applied to the cache's line valid bits later, one per cycle, whenever the tag port is not claimed by the core. Read-data replies do not pass through the queue. A reply fills its line at once, so it can overtake invalidations that arrived earlier.

Because of this, a dependent load can still hit a stale line while an invalidation for that line waits in the queue. A memory barrier closes that window. The core raises a barrier request, and the block reports completion only after every probe taken up to and including the request cycle has been applied. After completion, a load to any of those lines misses. Probes that arrive after the barrier do not hold it back. The cache itself is reduced to one valid bit per line index, with a combinational lookup port for loads.

Top module: `cpq_top`

## Requirements
- R1: A probe offered while `probeReady` is high is taken at the next clock edge, and `probeAck` is high in that same cycle. A queued probe leaves its line valid until the probe is serviced.
- R2: With DEPTH probes held, `probeReady` is low and an offered probe is neither acknowledged nor stored.
- R3: A reply to line L makes L hit from the cycle after the reply, even while probes for L are still queued.
- R4: When `tagBusy` is low and the queue is not empty, exactly one probe is serviced per cycle, in arrival order. `invValid` is high and `invAddr` shows the line in the service cycle, and that line misses from the next cycle. No probe is serviced while `tagBusy` is high.
- R5: After a one-cycle `barrierReq`, `barrierDone` pulses for exactly one cycle. The pulse comes in the first cycle in which every probe accepted up to and including the request cycle has been serviced. If the queue is empty, that is the cycle right after the request.
- R6: Probes accepted after the barrier request cycle do not delay `barrierDone`.
- R7: Once `barrierDone` has pulsed, a load to a line named by a probe accepted before the barrier misses.
- R8: If a reply fills a line in the same cycle that a queued probe invalidates that line, the line ends invalid.
- R9: After reset the queue is empty, `probeReady` is high, `barrierDone` and `invValid` are low, and every line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| probeValid | input | 1 | Invalidation probe offered |
| probeAddr | input | ADDR_W | Line index of the probe |
| probeReady | output | 1 | Queue can take a probe |
| probeAck | output | 1 | Probe taken this cycle |
| replyValid | input | 1 | Read-data reply fills a line |
| replyAddr | input | ADDR_W | Line index of the reply |
| tagBusy | input | 1 | Core holds the tag port; no probe service |
| barrierReq | input | 1 | One-cycle memory barrier request |
| barrierDone | output | 1 | Barrier completion pulse |
| invValid | output | 1 | Tag invalidate strobe |
| invAddr | output | ADDR_W | Line being invalidated |
| loadAddr | input | ADDR_W | Load lookup line index |
| loadHit | output | 1 | Lookup line is valid |

## Verification
The hardest case to reach is the stale hit itself. A reply must land on a line while an earlier probe for that line is still queued, and a barrier must then be raised with further probes arriving behind it. The stimulus holds `tagBusy` high so that probes pile up. During that time it issues replies and the barrier, then releases the tag port and watches the drain. It checks that the barrier completes before the later probe is serviced. A second sequence makes a reply and a service collide on the same line. A third fills the queue to depth, to exercise back-pressure.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } cpqStrobe_t;
endpackage

// File: rtl/cpq_ctrl.sv
module cpq_ctrl
  import cpq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       probeValid,
  input  logic       tagBusy,
  input  logic       barrierReq,
  output logic       probeReady,
  output logic       probeAck,
  output logic       barrierDone,
  output cpqStrobe_t strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] drainCnt;
  logic             drainBusy;
  logic             full;

  always_comb begin
    full        = (count == CNT_W'(DEPTH));
    probeReady  = !full;
    strobe.push = probeValid && !full;
    strobe.pop  = (count != '0) && !tagBusy;
    probeAck    = strobe.push;
    countNext   = count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    barrierDone = drainBusy && (drainCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      count <= countNext;
    end
  end

  // Barrier snapshot: probes held after this edge are the ones ahead of it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      drainBusy <= 1'b0;
      drainCnt  <= '0;
    end else if (drainBusy) begin
      if (drainCnt == '0) begin
        drainBusy <= 1'b0;
      end else if (strobe.pop) begin
        drainCnt <= drainCnt - 1'b1;
      end
    end else if (barrierReq) begin
      drainBusy <= 1'b1;
      drainCnt  <= countNext;
    end
  end
endmodule

// File: rtl/cpq_data.sv
module cpq_data
  import cpq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LINES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cpqStrobe_t               strobe,
  input  logic [$clog2(LINES)-1:0] probeAddr,
  input  logic                     replyValid,
  input  logic [$clog2(LINES)-1:0] replyAddr,
  input  logic [$clog2(LINES)-1:0] loadAddr,
  output logic                     invValid,
  output logic [$clog2(LINES)-1:0] invAddr,
  output logic                     loadHit
);
  localparam int ADDR_W = $clog2(LINES);
  localparam int PTR_W  = $clog2(DEPTH);

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [LINES-1:0]  lineValid;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) slots[wrPtr] <= probeAddr;
  end

  always_comb begin
    invValid = strobe.pop;
    invAddr  = slots[rdPtr];
    loadHit  = lineValid[loadAddr];
  end

  // One valid bit per line; an invalidation overrides a fill in the same cycle.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid[i] <= 1'b0;
      end else if (invValid && invAddr == ADDR_W'(i)) begin
        lineValid[i] <= 1'b0;
      end else if (replyValid && replyAddr == ADDR_W'(i)) begin
        lineValid[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpq_top.sv
module cpq_top
  import cpq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINES  = 16,
  localparam int ADDR_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              probeValid,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeReady,
  output logic              probeAck,
  input  logic              replyValid,
  input  logic [ADDR_W-1:0] replyAddr,
  input  logic              tagBusy,
  input  logic              barrierReq,
  output logic              barrierDone,
  output logic              invValid,
  output logic [ADDR_W-1:0] invAddr,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic              loadHit
);
  cpqStrobe_t strobe;

  cpq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .probeValid(probeValid), .tagBusy(tagBusy),
    .barrierReq(barrierReq), .probeReady(probeReady), .probeAck(probeAck),
    .barrierDone(barrierDone), .strobe(strobe)
  );

  cpq_data #(.DEPTH(DEPTH), .LINES(LINES)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .probeAddr(probeAddr),
    .replyValid(replyValid), .replyAddr(replyAddr), .loadAddr(loadAddr),
    .invValid(invValid), .invAddr(invAddr), .loadHit(loadHit)
  );
endmodule

// File: rtl/cpq_checker.sv
module cpq_checker #(
  parameter int DEPTH = 8
) (
  input logic clk,
  input logic rstN,
  input logic probeValid,
  input logic probeReady,
  input logic probeAck,
  input logic tagBusy,
  input logic barrierReq,
  input logic barrierDone,
  input logic invValid
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] ahead;
  logic             pend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ   <= '0;
      ahead <= '0;
      pend  <= 1'b0;
    end else begin
      occ <= occ + CNT_W'(probeAck) - CNT_W'(invValid);
      if (!pend) begin
        if (barrierReq) begin
          pend  <= 1'b1;
          ahead <= occ + CNT_W'(probeAck) - CNT_W'(invValid);
        end
      end else if (barrierDone) begin
        pend <= 1'b0;
      end else if (invValid) begin
        ahead <= ahead - 1'b1;
      end
    end
  end

  p_ack_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    probeAck |-> (probeValid && probeReady));
  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    !probeReady |-> (occ == CNT_W'(DEPTH)));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));
  p_inv_idle_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    tagBusy |-> !invValid);
  p_inv_has_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (occ != '0));
  p_done_drained_r5: assert property (@(posedge clk) disable iff (!rstN)
    barrierDone |-> (pend && ahead == '0));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    barrierDone |=> !barrierDone);
  p_done_prompt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pend && ahead == '0) |-> barrierDone);
endmodule

bind cpq_top cpq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .probeValid(probeValid), .probeReady(probeReady),
  .probeAck(probeAck), .tagBusy(tagBusy), .barrierReq(barrierReq),
  .barrierDone(barrierDone), .invValid(invValid)
);

// File: tb/sim_cpq_top.sv
`timescale 1ns/1ps
module sim_cpq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       probeValid = 1'b0;
  logic [3:0] probeAddr = '0;
  logic       probeReady, probeAck;
  logic       replyValid = 1'b0;
  logic [3:0] replyAddr = '0;
  logic       tagBusy = 1'b0;
  logic       barrierReq = 1'b0;
  logic       barrierDone, invValid;
  logic [3:0] invAddr;
  logic [3:0] loadAddr = '0;
  logic       loadHit;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  cpq_top #(.DEPTH(8), .LINES(16)) u0 (
    .clk(clk), .rstN(rstN), .probeValid(probeValid), .probeAddr(probeAddr),
    .probeReady(probeReady), .probeAck(probeAck), .replyValid(replyValid),
    .replyAddr(replyAddr), .tagBusy(tagBusy), .barrierReq(barrierReq),
    .barrierDone(barrierDone), .invValid(invValid), .invAddr(invAddr),
    .loadAddr(loadAddr), .loadHit(loadHit)
  );

  typedef struct packed {
    logic pv; logic [3:0] pa; logic rv; logic [3:0] ra; logic tb; logic br;
    logic [3:0] la;
    logic eRdy; logic eAck; logic eInv; logic [3:0] eIa; logic eDone; logic eHit;
  } vec_t;

  // Cycle-by-cycle walk: fill, queued probes, bypass fill, barrier, drain, collision.
  localparam vec_t VEC [19] = '{
    '{1'b0,4'd0,1'b1,4'd3,1'b0,1'b0,4'd3, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0},
    '{1'b1,4'd3,1'b0,4'd0,1'b1,1'b0,4'd3, 1'b1,1'b1,1'b0,4'd0,1'b0,1'b1},
    '{1'b1,4'd5,1'b0,4'd0,1'b1,1'b0,4'd3, 1'b1,1'b1,1'b0,4'd0,1'b0,1'b1},
    '{1'b0,4'd0,1'b1,4'd5,1'b1,1'b0,4'd3, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b1},
    '{1'b0,4'd0,1'b0,4'd0,1'b1,1'b1,4'd5, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b1},
    '{1'b1,4'd9,1'b0,4'd0,1'b1,1'b0,4'd5, 1'b1,1'b1,1'b0,4'd0,1'b0,1'b1},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd3, 1'b1,1'b0,1'b1,4'd3,1'b0,1'b1},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd3, 1'b1,1'b0,1'b1,4'd5,1'b0,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b1,1'b0,4'd5, 1'b1,1'b0,1'b0,4'd0,1'b1,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b1,1'b0,4'd5, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0},
    '{1'b0,4'd0,1'b1,4'd9,1'b0,1'b0,4'd9, 1'b1,1'b0,1'b1,4'd9,1'b0,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd9, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b1,4'd9, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd0,1'b1,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0},
    '{1'b1,4'd2,1'b0,4'd0,1'b1,1'b1,4'd0, 1'b1,1'b1,1'b0,4'd0,1'b0,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b1,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd2,1'b0,1'b0},
    '{1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd0,1'b1,1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    probeValid = 1'b0; replyValid = 1'b0; barrierReq = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    @(negedge clk); rstN = 1'b1; #1;
    check("R9 ready", int'(probeReady), 1);
    check("R9 done", int'(barrierDone), 0);
    check("R9 inv", int'(invValid), 0);
    for (int l = 0; l < 16; l += 5) begin
      loadAddr = 4'(l); #1;
      check("R9 line miss", int'(loadHit), 0);
    end

    // Vector walk: R1 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      probeValid = VEC[i].pv; probeAddr = VEC[i].pa;
      replyValid = VEC[i].rv; replyAddr = VEC[i].ra;
      tagBusy = VEC[i].tb; barrierReq = VEC[i].br; loadAddr = VEC[i].la;
      #1;
      check("R2 ready", int'(probeReady), int'(VEC[i].eRdy));
      check("R1 ack", int'(probeAck), int'(VEC[i].eAck));
      check("R4 invValid", int'(invValid), int'(VEC[i].eInv));
      if (VEC[i].eInv) check("R4 invAddr", int'(invAddr), int'(VEC[i].eIa));
      check("R5 R6 barrierDone", int'(barrierDone), int'(VEC[i].eDone));
      check("R3 R7 R8 loadHit", int'(loadHit), int'(VEC[i].eHit));
    end

    // R2: fill the queue to depth, then offer one more
    @(negedge clk); idle(); tagBusy = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); probeValid = 1'b1; probeAddr = 4'(k + 4); #1;
      check("R2 fill ack", int'(probeAck), 1);
    end
    @(negedge clk); probeAddr = 4'd15; #1;
    check("R2 full ready", int'(probeReady), 0);
    check("R2 full ack", int'(probeAck), 0);
    // R4: drain order, and the refused probe was not stored
    @(negedge clk); idle(); tagBusy = 1'b0; #1;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      check("R4 drain valid", int'(invValid), 1);
      check("R4 drain order", int'(invAddr), k + 4);
    end
    @(negedge clk); #1;
    check("R2 refused probe absent", int'(invValid), 0);
    check("R2 ready again", int'(probeReady), 1);

    @(negedge clk);
    finish_run();
  end
endmodule